// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It latches a channel address and decodes it into one-hot channel selects for an external analog multiplexer. On a falling edge of the start input it searches for the result one bit at a time, most significant bit first. Each trial code goes out on a DAC-code bus, and each decision is read back from a single comparator bit. When the search ends, the finished code is moved into an output register in one step. A one-cycle end-of-conversion pulse then announces the result, and an output enable gates the result onto the data bus.

The end-of-conversion pulse can be wired straight back to the start input. Its fall one clock after it rises is then the falling edge that launches the next conversion, so the converter runs on its own with a fixed period of 13 clocks. The start input is asynchronous to the converter clock and passes through a two-flop synchroniser before its edge is detected.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the trial code (`dac_code` = 0), the result (`data_out` = 0), the latched address (`chan_sel` = 8'h01) and holds `eoc` low.
- R2: While `addr_le` is high, each clock loads `ch_addr` into the address latch. While it is low, the latch holds. Latched address n drives `chan_sel` with only bit n set.
- R3: A conversion launches on a falling edge of `start_in`. Take edge k as the first rising clock edge that samples `start_in` low after it was high. After edge k+2, `dac_code` shows 8'h80, the MSB trial.
- R4: A rising edge of `start_in` starts nothing: `eoc` stays low and `dac_code` is unchanged.
- R5: The search runs from bit 7 down to bit 0, taking one clock per bit. On each trial clock the bit under test is kept if `cmp_ge` is 1 (input at or above `dac_code`) and cleared if it is 0, and the next lower bit is set. For an ideal comparator, the result equals the 8-bit input value, including 8'h00 and 8'hFF.
- R6: `eoc` rises after edge k+11 and stays high for exactly one clock.
- R7: The result register changes only in the cycle where `eoc` goes high, so the data bus never shows a partly converted code.
- R8: A falling edge of `start_in` during a conversion abandons it with no `eoc` pulse and restarts from the MSB. The result then reflects the input seen by the new search.
- R9: With `out_en` low, `data_out` is 0. With it high, `data_out` shows the result register.
- R10: With `eoc` fed back to `start_in`, conversions repeat on their own every 13 clocks, and each pulse delivers a fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_addr | input | 3 | Channel address |
| addr_le | input | 1 | Address latch enable, active high |
| start_in | input | 1 | Start request; the falling edge launches a conversion |
| out_en | input | 1 | Data bus enable, active high |
| cmp_ge | input | 1 | Comparator: 1 when the analog input is at or above `dac_code` |
| chan_sel | output | 8 | One-hot analog channel select |
| dac_code | output | 8 | Current trial code for the external DAC |
| eoc | output | 1 | End-of-conversion pulse |
| data_out | output | 8 | Gated conversion result |

## Verification
Every result comes at a fixed distance from the clock edge that first samples `start_in` low. The MSB trial code appears two edges later. `eoc` is still low ten edges later and high eleven edges later, together with the new data. A changed address shows on `chan_sel` one edge after it is latched. The bench drives inputs on falling clock edges and counts falling edges from the one where it lowers `start_in`. It samples at the 3rd, 11th and 12th of those edges, and it counts `eoc` pulses so that a missing pulse or an extra one is caught. In free-running mode it measures the gap between pulses directly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_LOAD  = 2'd2
  } sar_state_t;
endpackage

// File: rtl/start_edge_sync.sv
module start_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[LAST-1:0], start_in};
  end

  // one stage past the synchroniser is high, the synchronised value is low
  assign fall_o = shreg[LAST] & ~shreg[LAST-1];
endmodule

// File: rtl/chan_latch.sv
module chan_latch #(
  parameter int N_CH = 8,
  localparam int AW = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr_in,
  input  logic            le,
  output logic [N_CH-1:0] sel_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)     addr_q <= '0;
    else if (le) addr_q <= addr_in;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign sel_o[i] = (addr_q == AW'(i));
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(sel_o));
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         cmp_ge,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] result_o,
  output logic         eoc_o
);
  localparam logic [W-1:0]  MSB_ONE = W'(1) << (W - 1);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  sar_state_t    state;
  logic [W-1:0]  trial;
  logic [IW-1:0] idx;
  logic [W-1:0]  result;
  logic          eoc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      trial  <= '0;
      idx    <= '0;
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (launch) begin
        state <= ST_TRIAL;
        trial <= MSB_ONE;
        idx   <= TOP_IDX;
      end else begin
        case (state)
          ST_TRIAL: begin
            trial[idx] <= cmp_ge;
            if (idx == '0) begin
              state <= ST_LOAD;
            end else begin
              trial[idx - 1'b1] <= 1'b1;
              idx               <= idx - 1'b1;
            end
          end
          ST_LOAD: begin
            result <= trial;
            eoc    <= 1'b1;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign trial_o  = trial;
  assign result_o = result;
  assign eoc_o    = eoc;

  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (trial_o == MSB_ONE));
  // R6
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o);
  // R7
  result_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> eoc_o);
  // R8
  launch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> !eoc_o);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W   = 8,
  parameter int N_CH    = 8,
  parameter int SYNC_FF = 2,
  localparam int AW = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    ch_addr,
  input  logic             addr_le,
  input  logic             start_in,
  input  logic             out_en,
  input  logic             cmp_ge,
  output logic [N_CH-1:0]  chan_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             eoc,
  output logic [RES_W-1:0] data_out
);
  logic             launch;
  logic [RES_W-1:0] result;

  start_edge_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .start_in(start_in), .fall_o(launch)
  );

  chan_latch #(.N_CH(N_CH)) u_chan (
    .clk(clk), .rst(rst), .addr_in(ch_addr), .le(addr_le), .sel_o(chan_sel)
  );

  sar_engine #(.W(RES_W)) u_eng (
    .clk(clk), .rst(rst), .launch(launch), .cmp_ge(cmp_ge),
    .trial_o(dac_code), .result_o(result), .eoc_o(eoc)
  );

  assign data_out = out_en ? result : '0;

  // R4
  rise_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_in) |=> !eoc || $past(eoc));
endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ch_addr = '0;
  logic       addr_le = 1'b0;
  logic       start_drv = 1'b0;
  logic       loop_en = 1'b0;
  logic       kick = 1'b0;
  logic       out_en = 1'b1;
  logic       cmp_ge;
  logic       start_in;
  logic [7:0] chan_sel, dac_code, data_out;
  logic       eoc;
  logic [7:0] analog [8];
  int         n_chk = 0, n_bad = 0, eoc_cnt = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  assign start_in = loop_en ? (eoc | kick) : start_drv;

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst(rst), .ch_addr(ch_addr), .addr_le(addr_le),
    .start_in(start_in), .out_en(out_en), .cmp_ge(cmp_ge),
    .chan_sel(chan_sel), .dac_code(dac_code), .eoc(eoc), .data_out(data_out)
  );

  function automatic int idx_of(input logic [7:0] oh);
    for (int i = 0; i < 8; i++) if (oh[i]) return i;
    return 0;
  endfunction

  function automatic logic [7:0] onehot(input int n);
    return 8'(1) << n;
  endfunction

  always_comb cmp_ge = (analog[idx_of(chan_sel)] >= dac_code);

  always @(posedge clk) if (!rst && eoc) eoc_cnt <= eoc_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_conv(input int ch, input logic [7:0] v);
    int base;
    @(negedge clk); ch_addr = 3'(ch); addr_le = 1'b1; analog[ch] = v;
    @(negedge clk); addr_le = 1'b0; start_drv = 1'b1;
    chk("R2 chan_sel", chan_sel, onehot(ch));
    @(negedge clk); @(negedge clk); start_drv = 1'b0;
    base = eoc_cnt;
    repeat (3) @(negedge clk);
    chk("R3 msb trial", dac_code, 8'h80);
    repeat (8) @(negedge clk);
    chk("R6 eoc low before done", eoc, 0);
    @(negedge clk);
    chk("R6 eoc high", eoc, 1);
    chk("R5 result", data_out, v);
    @(negedge clk);
    chk("R6 eoc one cycle", eoc, 0);
    chk("R6 single pulse", eoc_cnt, base + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int base, gap;
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) analog[i] = 8'(i * 17 + 5);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dac_code", dac_code, 0);
    chk("R1 data_out", data_out, 0);
    chk("R1 chan_sel", chan_sel, 8'h01);
    chk("R1 eoc", eoc, 0);

    // R5 directed corners
    run_conv(0, 8'h00);
    run_conv(7, 8'hFF);
    run_conv(3, 8'h80);
    run_conv(5, 8'h7F);
    run_conv(1, 8'h55);

    // R2 latch holds while enable low
    @(negedge clk); ch_addr = 3'd6; addr_le = 1'b0;
    @(negedge clk); chk("R2 hold", chan_sel, onehot(1));
    addr_le = 1'b1;
    @(negedge clk); addr_le = 1'b0;
    chk("R2 load", chan_sel, onehot(6));

    // R9 output enable
    out_en = 1'b0;
    @(negedge clk); chk("R9 gated", data_out, 0);
    out_en = 1'b1;
    @(negedge clk); chk("R9 enabled", data_out, 8'h55);

    // R4 rising edge does nothing
    base = eoc_cnt; v = dac_code;
    start_drv = 1'b1;
    repeat (15) @(negedge clk);
    chk("R4 no eoc", eoc_cnt, base);
    chk("R4 dac unchanged", dac_code, v);
    chk("R4 data unchanged", data_out, 8'h55);

    // R8 restart mid-conversion
    @(negedge clk); ch_addr = 3'd2; addr_le = 1'b1; analog[2] = 8'h3C;
    @(negedge clk); addr_le = 1'b0; start_drv = 1'b0;
    repeat (5) @(negedge clk);
    analog[2] = 8'hC3; start_drv = 1'b1;
    repeat (2) @(negedge clk);
    start_drv = 1'b0; base = eoc_cnt;
    repeat (3) @(negedge clk);
    chk("R8 restart at msb", dac_code, 8'h80);
    repeat (8) @(negedge clk);
    chk("R8 no eoc from abandoned run", eoc_cnt, base);
    @(negedge clk);
    chk("R8 eoc after restart", eoc, 1);
    chk("R8 result of new search", data_out, 8'hC3);

    // R5 random conversions
    for (int n = 0; n < 25; n++) begin
      run_conv(int'($urandom_range(7, 0)), 8'($urandom));
    end

    // R10 free-running
    @(negedge clk); ch_addr = 3'd4; addr_le = 1'b1; analog[4] = 8'h21;
    @(negedge clk); addr_le = 1'b0; start_drv = 1'b0; loop_en = 1'b1; kick = 1'b1;
    repeat (2) @(negedge clk); kick = 1'b0;
    gap = 0;
    while (!eoc && gap < 40) begin @(negedge clk); gap++; end
    chk("R10 first pulse", eoc, 1);
    chk("R10 first result", data_out, 8'h21);
    for (int p = 0; p < 4; p++) begin
      v = 8'($urandom);
      analog[4] = v;
      gap = 0;
      @(negedge clk); gap++;
      while (!eoc && gap < 40) begin @(negedge clk); gap++; end
      chk("R10 period", gap, 13);
      chk("R10 fresh result", data_out, v);
    end
    loop_en = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule